// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block puts a one-time-programmable fuse array behind a 32-bit register bus. The array holds eight banks of byte-wide words, and each fuse bit is modelled as a sticky flip-flop. Software uses it in three ways:

- It reads a word's fuse contents with an explicit sense cycle.
- It burns single fuse bits, one bit per command. Each burn needs a key in a protect register.
- It reads or overrides a per-word shadow copy. The shadow is what the rest of the chip consumes.

The target word is taken from a bank/row/bit address split across an upper and a lower address register.

A sense or program operation holds a busy flag for a fixed number of clocks. It then raises its own done flag. Every way an operation can be refused has its own sticky error flag. Status and error flags are cleared by writing ones to them.

The fuse model has a separate power-on clear, `por`. It stands for non-volatile contents, so fuses survive the controller reset `rst`. The shadow words are reloaded from the fuses whenever `rst` is asserted, and the addressed bank is reloaded after each completed burn.

Top module: `fuse_ctrl`

## Requirements
- R1: After `rst` (with `por`), status, error, function control and sense data read 0. Every shadow word reads the fuse contents, which are 0 after `por`.
- R2: Registers are at word index 0 status, 1 status mask, 2 error, 3 error mask, 4 function control, 5 upper address, 6 lower address, 7 sense data, 8 protect key. Mask, key and lower address keep 8 bits. Upper address keeps 6 bits. Upper data bits read 0.
- R3: Writing function control with bit 3 set (and bit 0 clear) starts a sense. Status bit 7 (busy) reads 1 for SENSE_CYCLES clocks. After that, status bit 0 is set and sense data holds the fuse byte of the addressed word.
- R4: Writing function control bit 0 while the key register holds 0xAA starts a program. Busy lasts PROG_CYCLES clocks. The fuse bit at bank = upper[5:3], word = {upper[2:0], lower[7:3]}, bit = lower[2:0] is then burned, status bit 1 is set, and every shadow word of that bank is reloaded from the fuses.
- R5: A program start with any other key value sets error bit 6, does not go busy, burns nothing, and leaves function control bit 0 clear.
- R6: Fuse bits only ever change from 0 to 1. Burning a second bit of a word keeps the first one.
- R7: Function-control writes made while busy are ignored. No operation is started and the register keeps its value.
- R8: Start bits 0 and 3 read back as 1 while their operation runs and clear when it finishes. Writing both starts only the program.
- R9: A bus write to shadow index 0x800 | bank<<8 | word replaces that shadow byte and leaves the fuses unchanged. A later `rst` restores the fuse value.
- R10: A shadow write to a bank whose `lock_ovr` bit is set leaves the shadow unchanged and sets error bit 5. A shadow write with any of data bits 31:8 set leaves the shadow unchanged and sets error bit 3.
- R11: A shadow read of a bank whose `lock_read` bit is set returns 0 and sets error bit 4.
- R12: Writing ones to status bits 1:0 or error bits 7:1 clears exactly those bits. Busy is unaffected.
- R13: A word index at or above 2**WORD_AW is outside the implemented array. A program there sets error bit 7, a sense there sets error bit 2, neither goes busy, and shadow reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset; reloads shadows |
| por | input | 1 | Synchronous power-on clear of the fuse model |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Word index: registers at 0..8, shadows at 0x800 and up |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| lock_read | input | 8 | Per-bank shadow read lock |
| lock_ovr | input | 8 | Per-bank shadow override lock |

## Verification
Read data is combinational. It is sampled mid-cycle while the read strobe is held. The side effects of a read or write, such as error flags, shadow updates and refused starts, become visible from the next access onward.

A start written at edge k keeps busy high through edge k+N-1. It finishes at edge k+N, where N is SENSE_CYCLES or PROG_CYCLES. The bench therefore waits N-2 edges (N-3 when it has first read function control), then reads status three times in a row. It expects busy, busy and then the done flag alone. This pins the finish to a single edge.

The shadow sweep expects values computed from the bank index. Every other expected value comes from the requirement's own encoding.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int BANK_AW   = 3;
    localparam int NUM_BANKS = 1 << BANK_AW;
    localparam int BUS_AW    = 12;

    typedef enum logic [3:0] {
        RG_STAT  = 4'd0,
        RG_STATM = 4'd1,
        RG_ERR   = 4'd2,
        RG_EMASK = 4'd3,
        RG_FCTL  = 4'd4,
        RG_UADDR = 4'd5,
        RG_LADDR = 4'd6,
        RG_SDATA = 4'd7,
        RG_KEY   = 4'd8
    } reg_idx_e;

    localparam int ST_BUSY  = 7;
    localparam int ST_PDONE = 1;
    localparam int ST_SDONE = 0;

    localparam int ER_PROG  = 7;
    localparam int ER_WPROT = 6;
    localparam int ER_OPROT = 5;
    localparam int ER_RPROT = 4;
    localparam int ER_LEN   = 3;
    localparam int ER_SENSE = 2;

    localparam int FC_PROG  = 0;
    localparam int FC_SENSE = 3;

    localparam logic [7:0] BURN_KEY = 8'hAA;

    typedef enum logic {OP_SENSE = 1'b0, OP_PROG = 1'b1} op_e;

    typedef struct packed {
        logic [BANK_AW-1:0] bank;
        logic [7:0]         word;
        logic [2:0]         bitn;
    } fuse_loc_t;

    function automatic fuse_loc_t split_loc(input logic [5:0] upper, input logic [7:0] lower);
        fuse_loc_t l;
        l.bank = upper[5:3];
        l.word = {upper[2:0], lower[7:3]};
        l.bitn = lower[2:0];
        return l;
    endfunction

    function automatic logic word_fits(input logic [7:0] word, input int aw);
        return (word >> aw) == 8'd0;
    endfunction

endpackage

// File: rtl/fuse_array.sv
module fuse_array
    import fuse_pkg::*;
#(
    parameter int WORD_AW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               por,
    input  logic               burn_en,
    input  logic [BANK_AW-1:0] burn_bank,
    input  logic [WORD_AW-1:0] burn_word,
    input  logic [2:0]         burn_bit,
    input  logic               ovr_en,
    input  logic [BANK_AW-1:0] ovr_bank,
    input  logic [WORD_AW-1:0] ovr_word,
    input  logic [7:0]         ovr_data,
    input  logic [BANK_AW-1:0] rd_bank,
    input  logic [WORD_AW-1:0] rd_word,
    output logic [7:0]         rd_shadow,
    input  logic [BANK_AW-1:0] sn_bank,
    input  logic [WORD_AW-1:0] sn_word,
    output logic [7:0]         sn_fuse
);
    localparam int NW    = 1 << WORD_AW;
    localparam int CELLS = NUM_BANKS * NW;

    logic [CELLS*8-1:0] fuse_vec;
    logic [CELLS*8-1:0] shadow_vec;
    logic [7:0]         burn_mask;

    assign burn_mask = 8'b1 << burn_bit;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar w = 0; w < NW; w++) begin : g_word
            logic [7:0] fuse_cell;
            logic [7:0] shadow_cell;
            logic       hit_burn;
            logic       hit_bank;

            assign hit_bank = burn_en && (burn_bank == BANK_AW'(b));
            assign hit_burn = hit_bank && (burn_word == WORD_AW'(w));

            always_ff @(posedge clk) begin
                if (por)
                    fuse_cell <= 8'h00;
                else if (hit_burn)
                    fuse_cell <= fuse_cell | burn_mask;
            end

            always_ff @(posedge clk) begin
                if (rst)
                    shadow_cell <= fuse_cell;
                else if (hit_bank)
                    shadow_cell <= fuse_cell | (hit_burn ? burn_mask : 8'h00);
                else if (ovr_en && ovr_bank == BANK_AW'(b) && ovr_word == WORD_AW'(w))
                    shadow_cell <= ovr_data;
            end

            assign fuse_vec[(b*NW+w)*8 +: 8]   = fuse_cell;
            assign shadow_vec[(b*NW+w)*8 +: 8] = shadow_cell;

            // R6: a fuse bit once set never returns to 0
            assert_fuse_sticky_R6: assert property (@(posedge clk) disable iff (por)
                (fuse_cell & $past(fuse_cell)) == $past(fuse_cell));
        end
    end

    assign rd_shadow = shadow_vec[{rd_bank, rd_word, 3'b000} +: 8];
    assign sn_fuse   = fuse_vec[{sn_bank, sn_word, 3'b000} +: 8];

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int SENSE_CYCLES = 16,
    parameter int PROG_CYCLES  = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start_prog,
    input  logic start_sense,
    output logic busy,
    output logic fin_prog,
    output logic fin_sense
);
    localparam int MAXC  = (SENSE_CYCLES > PROG_CYCLES) ? SENSE_CYCLES : PROG_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    op_e              op_q;
    logic             fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_SENSE;
        end else if (!busy_q) begin
            if (start_prog) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(PROG_CYCLES - 1);
                op_q   <= OP_PROG;
            end else if (start_sense) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(SENSE_CYCLES - 1);
                op_q   <= OP_SENSE;
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign fin       = busy_q && (cnt_q == '0);
    assign fin_prog  = fin && (op_q == OP_PROG);
    assign fin_sense = fin && (op_q == OP_SENSE);
    assign busy      = busy_q;

    // R3: an accepted sense start enters the busy period as a sense
    assert_sense_starts_R3: assert property (@(posedge clk) disable iff (rst)
        (start_sense && !start_prog && !busy_q) |=> (busy_q && op_q == OP_SENSE));
    // R8: a program request wins over a simultaneous sense request
    assert_prog_priority_R8: assert property (@(posedge clk) disable iff (rst)
        (start_prog && !busy_q) |=> (busy_q && op_q == OP_PROG));

endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
    import fuse_pkg::*;
#(
    parameter int WORD_AW      = 5,
    parameter int SENSE_CYCLES = 16,
    parameter int PROG_CYCLES  = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [7:0]  lock_read,
    input  logic [7:0]  lock_ovr
);
    logic [7:0] statm_q, emask_q, fctl_q, lower_q, sdata_q, key_q, err_q;
    logic [5:0] upper_q;
    logic       pdone_q, sdone_q;
    fuse_loc_t  op_q, cur;

    logic wr, rd, is_shadow, reg_hit;
    logic [3:0] ridx;
    logic [BANK_AW-1:0] sh_bank;
    logic [7:0] sh_word;
    logic sh_fits, cur_fits, key_ok;
    logic fctl_wr, stat_wr, err_wr;
    logic req_prog, req_sense, go_prog, go_sense;
    logic busy, fin_prog, fin_sense, fin_any;
    logic ovr_en;
    logic [7:0] err_set, rd_shadow, sn_fuse;

    assign wr        = bus_sel && bus_wr;
    assign rd        = bus_sel && !bus_wr;
    assign is_shadow = bus_addr[11];
    assign reg_hit   = !bus_addr[11] && (bus_addr[10:4] == 7'd0);
    assign ridx      = bus_addr[3:0];
    assign sh_bank   = bus_addr[10:8];
    assign sh_word   = bus_addr[7:0];
    assign sh_fits   = word_fits(sh_word, WORD_AW);

    assign cur      = split_loc(upper_q, lower_q);
    assign cur_fits = word_fits(cur.word, WORD_AW);
    assign key_ok   = (key_q == BURN_KEY);

    assign fctl_wr = wr && reg_hit && (ridx == RG_FCTL);
    assign stat_wr = wr && reg_hit && (ridx == RG_STAT);
    assign err_wr  = wr && reg_hit && (ridx == RG_ERR);

    assign req_prog  = fctl_wr && !busy && bus_wdata[FC_PROG];
    assign req_sense = fctl_wr && !busy && bus_wdata[FC_SENSE] && !bus_wdata[FC_PROG];
    assign go_prog   = req_prog && key_ok && cur_fits;
    assign go_sense  = req_sense && cur_fits;
    assign fin_any   = fin_prog || fin_sense;

    assign ovr_en = wr && is_shadow && sh_fits && !lock_ovr[sh_bank] && (bus_wdata[31:8] == 24'd0);

    always_comb begin
        err_set           = 8'h00;
        err_set[ER_WPROT] = req_prog && !key_ok;
        err_set[ER_PROG]  = req_prog && key_ok && !cur_fits;
        err_set[ER_SENSE] = req_sense && !cur_fits;
        err_set[ER_OPROT] = wr && is_shadow && lock_ovr[sh_bank];
        err_set[ER_LEN]   = wr && is_shadow && (bus_wdata[31:8] != 24'd0);
        err_set[ER_RPROT] = rd && is_shadow && lock_read[sh_bank];
    end

    fuse_seq #(
        .SENSE_CYCLES(SENSE_CYCLES),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_prog (go_prog),
        .start_sense(go_sense),
        .busy       (busy),
        .fin_prog   (fin_prog),
        .fin_sense  (fin_sense)
    );

    fuse_array #(.WORD_AW(WORD_AW)) u_array (
        .clk      (clk),
        .rst      (rst),
        .por      (por),
        .burn_en  (fin_prog),
        .burn_bank(op_q.bank),
        .burn_word(op_q.word[WORD_AW-1:0]),
        .burn_bit (op_q.bitn),
        .ovr_en   (ovr_en),
        .ovr_bank (sh_bank),
        .ovr_word (sh_word[WORD_AW-1:0]),
        .ovr_data (bus_wdata[7:0]),
        .rd_bank  (sh_bank),
        .rd_word  (sh_word[WORD_AW-1:0]),
        .rd_shadow(rd_shadow),
        .sn_bank  (op_q.bank),
        .sn_word  (op_q.word[WORD_AW-1:0]),
        .sn_fuse  (sn_fuse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            statm_q <= '0;
            emask_q <= '0;
            upper_q <= '0;
            lower_q <= '0;
            key_q   <= '0;
        end else if (wr && reg_hit) begin
            case (ridx)
                RG_STATM: statm_q <= bus_wdata[7:0];
                RG_EMASK: emask_q <= bus_wdata[7:0];
                RG_UADDR: upper_q <= bus_wdata[5:0];
                RG_LADDR: lower_q <= bus_wdata[7:0];
                RG_KEY:   key_q   <= bus_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            fctl_q <= '0;
        else if (fin_any)
            fctl_q <= fctl_q & ~((8'h1 << FC_PROG) | (8'h1 << FC_SENSE));
        else if (fctl_wr && !busy)
            fctl_q <= {bus_wdata[7:4], go_sense, bus_wdata[2:1], go_prog};
    end

    always_ff @(posedge clk) begin
        if (rst)
            op_q <= '0;
        else if (go_prog || go_sense)
            op_q <= cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pdone_q <= 1'b0;
            sdone_q <= 1'b0;
            sdata_q <= '0;
            err_q   <= '0;
        end else begin
            pdone_q <= (pdone_q && !(stat_wr && bus_wdata[ST_PDONE])) || fin_prog;
            sdone_q <= (sdone_q && !(stat_wr && bus_wdata[ST_SDONE])) || fin_sense;
            if (fin_sense)
                sdata_q <= sn_fuse;
            err_q <= ((err_q & ~(err_wr ? bus_wdata[7:0] : 8'h00)) | err_set) & 8'hFE;
        end
    end

    always_comb begin
        bus_rdata = 32'd0;
        if (is_shadow) begin
            if (sh_fits && !lock_read[sh_bank])
                bus_rdata = {24'd0, rd_shadow};
        end else if (reg_hit) begin
            case (ridx)
                RG_STAT:  bus_rdata = {24'd0, busy, 5'd0, pdone_q, sdone_q};
                RG_STATM: bus_rdata = {24'd0, statm_q};
                RG_ERR:   bus_rdata = {24'd0, err_q};
                RG_EMASK: bus_rdata = {24'd0, emask_q};
                RG_FCTL:  bus_rdata = {24'd0, fctl_q};
                RG_UADDR: bus_rdata = {26'd0, upper_q};
                RG_LADDR: bus_rdata = {24'd0, lower_q};
                RG_SDATA: bus_rdata = {24'd0, sdata_q};
                RG_KEY:   bus_rdata = {24'd0, key_q};
                default:  bus_rdata = 32'd0;
            endcase
        end
    end

    // R5: a refused burn request never enters the busy period
    assert_no_busy_wrong_key_R5: assert property (@(posedge clk) disable iff (rst)
        (req_prog && !key_ok) |=> !busy);
    // R3: the end of a busy period always leaves a done flag behind
    assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (pdone_q || sdone_q));
    // R7: control writes during a running operation change nothing
    assert_fctl_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (fctl_wr && busy && !fin_any) |=> $stable(fctl_q));
    // R12: write-one-to-clear on the error flags
    assert_err_w1c_R12: assert property (@(posedge clk) disable iff (rst)
        err_wr |=> ((err_q & $past(bus_wdata[7:0])) == 8'h00));
    // R11: a locked shadow read raises its flag
    assert_read_lock_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (rd && is_shadow && lock_read[sh_bank]) |=> err_q[ER_RPROT]);
    // R10: a locked shadow write raises its flag
    assert_ovr_lock_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (wr && is_shadow && lock_ovr[sh_bank]) |=> err_q[ER_OPROT]);

endmodule

// File: tb/tb_fuse_ctrl.sv
module tb_fuse_ctrl;
    localparam int SC = 16;
    localparam int PC = 64;

    localparam logic [11:0] A_STAT = 12'h000, A_STATM = 12'h001, A_ERR = 12'h002,
                            A_EMASK = 12'h003, A_FCTL = 12'h004, A_UP = 12'h005,
                            A_LO = 12'h006, A_SDAT = 12'h007, A_KEY = 12'h008;

    logic        clk = 1'b0;
    logic        rst, por;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lock_read = '0, lock_ovr = '0;

    int n_run = 0, n_fail = 0;
    logic [31:0] d;

    always #2.5 clk = ~clk;

    fuse_ctrl #(.WORD_AW(5), .SENSE_CYCLES(SC), .PROG_CYCLES(PC)) dut (
        .clk(clk), .rst(rst), .por(por), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lock_read(lock_read), .lock_ovr(lock_ovr)
    );

    function automatic logic [11:0] sh(input int b, input int w);
        return 12'h800 | 12'(b << 8) | 12'(w);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // start an operation, confirm the control readback, then pin the finish edge
    task automatic run_op(input string req, input logic [31:0] fv, input int cyc,
                          input logic [31:0] fctl_exp, input logic [31:0] done_exp);
        wr(A_FCTL, fv);
        expect_rd({req, " fctl running"}, A_FCTL, fctl_exp);
        repeat (cyc - 3) @(posedge clk);
        @(negedge clk);
        expect_rd({req, " busy"}, A_STAT, 32'h80);
        expect_rd({req, " busy last"}, A_STAT, 32'h80);
        expect_rd({req, " done"}, A_STAT, done_exp);
        expect_rd("R8 start bits self-clear", A_FCTL, fctl_exp & ~32'h09);
        wr(A_STAT, 32'h03);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; por = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; por = 1'b0;

        // R1 reset state
        expect_rd("R1 status", A_STAT, 32'h0);
        expect_rd("R1 error", A_ERR, 32'h0);
        expect_rd("R1 fctl", A_FCTL, 32'h0);
        expect_rd("R1 sense data", A_SDAT, 32'h0);
        expect_rd("R1 shadow", sh(5, 17), 32'h0);

        // R2 storage registers and widths
        wr(A_STATM, 32'hFFFF_FF03);
        expect_rd("R2 status mask", A_STATM, 32'h03);
        wr(A_EMASK, 32'h0000_01FE);
        expect_rd("R2 error mask", A_EMASK, 32'hFE);
        wr(A_UP, 32'hFFFF_FFFF);
        expect_rd("R2 upper width", A_UP, 32'h3F);
        wr(A_LO, 32'h0000_1245);
        expect_rd("R2 lower", A_LO, 32'h45);

        // R5 program without key: bank 2, word 3, bit 4
        wr(A_UP, 32'h10);
        wr(A_LO, 32'h1C);
        wr(A_FCTL, 32'h01);
        expect_rd("R5 write-protect flag", A_ERR, 32'h40);
        expect_rd("R5 not busy", A_STAT, 32'h00);
        expect_rd("R5 start not kept", A_FCTL, 32'h00);
        expect_rd("R5 nothing burned", sh(2, 3), 32'h00);
        wr(A_ERR, 32'h40);
        expect_rd("R12 error cleared", A_ERR, 32'h00);

        // R4 program with key; override elsewhere in bank 2 is wiped by the reload
        wr(sh(2, 7), 32'h5A);
        expect_rd("R9 override", sh(2, 7), 32'h5A);
        wr(A_KEY, 32'hAA);
        run_op("R4 program bit4", 32'h01, PC, 32'h01, 32'h02);
        expect_rd("R4 burned bit", sh(2, 3), 32'h10);
        expect_rd("R4 bank reload", sh(2, 7), 32'h00);

        // R6 second bit keeps the first
        wr(A_LO, 32'h1D);
        run_op("R6 program bit5", 32'h01, PC, 32'h01, 32'h02);
        expect_rd("R6 sticky bits", sh(2, 3), 32'h30);

        // R3 sense of the same word
        wr(A_LO, 32'h18);
        run_op("R3 sense", 32'h08, SC, 32'h08, 32'h01);
        expect_rd("R3 sense data", A_SDAT, 32'h30);

        // R7 start written while busy is ignored
        wr(A_FCTL, 32'h08);
        wr(A_FCTL, 32'h01);
        expect_rd("R7 fctl unchanged", A_FCTL, 32'h08);
        repeat (PC + 20) @(posedge clk);
        @(negedge clk);
        expect_rd("R7 no program done", A_STAT, 32'h01);
        expect_rd("R7 nothing burned", sh(2, 3), 32'h30);

        // R12 partial clear of status
        wr(A_LO, 32'h18);
        wr(A_FCTL, 32'h01);
        repeat (PC + 4) @(posedge clk);
        @(negedge clk);
        expect_rd("R12 both done", A_STAT, 32'h03);
        wr(A_STAT, 32'h82);
        expect_rd("R12 only program-done cleared", A_STAT, 32'h01);
        wr(A_STAT, 32'h01);
        expect_rd("R4 bit0 burned", sh(2, 3), 32'h31);

        // R8 both start bits: program only (bit 6 of word 3)
        wr(A_LO, 32'h1E);
        run_op("R8 both bits", 32'h09, PC, 32'h01, 32'h02);
        expect_rd("R8 program happened", sh(2, 3), 32'h71);

        // R9 override, then controller reset restores fuse values
        wr(sh(1, 4), 32'hC3);
        expect_rd("R9 override readback", sh(1, 4), 32'hC3);
        wr(A_UP, 32'h08);
        wr(A_LO, 32'h20);
        run_op("R9 sense overridden word", 32'h08, SC, 32'h08, 32'h01);
        expect_rd("R9 fuse untouched", A_SDAT, 32'h00);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        expect_rd("R9 shadow restored", sh(1, 4), 32'h00);
        expect_rd("R9 fuses survive reset", sh(2, 3), 32'h71);

        // R9 sweep across all banks
        for (int b = 0; b < 8; b++)
            wr(sh(b, (b * 5 + 1) % 32), 32'((b * 37 + 5) & 8'hFF));
        for (int b = 0; b < 8; b++)
            expect_rd("R9 sweep", sh(b, (b * 5 + 1) % 32), 32'((b * 37 + 5) & 8'hFF));

        // R10 override lock and wrong length
        lock_ovr = 8'h02;
        wr(sh(1, 9), 32'h77);
        expect_rd("R10 locked unchanged", sh(1, 9), 32'h00);
        expect_rd("R10 override-protect flag", A_ERR, 32'h20);
        wr(A_ERR, 32'hFF);
        wr(sh(0, 0), 32'h1FF);
        expect_rd("R10 long write unchanged", sh(0, 0), 32'h00);
        expect_rd("R10 length flag", A_ERR, 32'h08);
        wr(A_ERR, 32'h08);
        lock_ovr = 8'h00;

        // R11 read lock
        lock_read = 8'h04;
        expect_rd("R11 locked read zero", sh(2, 3), 32'h00);
        expect_rd("R11 read-protect flag", A_ERR, 32'h10);
        wr(A_ERR, 32'h10);
        lock_read = 8'h00;
        expect_rd("R11 unlocked again", sh(2, 3), 32'h71);

        // R13 word 32 is outside the array
        wr(A_KEY, 32'hAA);
        wr(A_UP, 32'h01);
        wr(A_LO, 32'h00);
        wr(A_FCTL, 32'h01);
        expect_rd("R13 program range flag", A_ERR, 32'h80);
        expect_rd("R13 program not busy", A_STAT, 32'h00);
        wr(A_ERR, 32'h80);
        wr(A_FCTL, 32'h08);
        expect_rd("R13 sense range flag", A_ERR, 32'h04);
        expect_rd("R13 sense not busy", A_STAT, 32'h00);
        wr(A_ERR, 32'h04);
        wr(sh(0, 40), 32'h55);
        expect_rd("R13 out-of-range read", sh(0, 40), 32'h00);
        expect_rd("R13 no error", A_ERR, 32'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule